// File: doc/BRIEF.md
# Instruction Control-Word Decoder

This block takes the 16-bit control word that opens every instruction and splits it into its fields: opcode, operation size, condition code and the operand kinds for the source and target slots. It uses a fixed per-opcode table to find how many operand slots the opcode uses. From each used slot's kind and the operation size it works out how many operand bytes follow. The sum of the control word and those bytes gives the full instruction length. It also tests the condition code against the zero and carry flags supplied with the word, which yields an execute-or-skip decision, and it flags any encoding that cannot be legal.

The decoder is a small state machine. In `ST_IDLE` it accepts a control word on `cw_valid` and registers the decoded result, which appears one cycle later with a one-cycle `dec_valid` pulse. A legal word that carries operands moves the machine to `ST_SRC`, where it counts off the source operand bytes offered on `opb_valid`/`opb`. It then moves to `ST_TGT` for the target bytes, if the opcode has a target slot, and returns to `ST_IDLE`. The transitions are:

- IDLE→SRC on a legal word with operands.
- SRC→TGT on the last source byte when there are target bytes.
- SRC→IDLE on the last source byte when there are none.
- TGT→IDLE on the last target byte.
- IDLE→IDLE on an illegal word or a word without operands.

While the machine walks the operand bytes it checks every byte of a register or register-pointer operand against the highest register number.

Top module: `cwd_decoder`

## Requirements
- R1: One cycle after a word is accepted, the outputs carry its raw fields: `src_kind`=bits 1:0, `tgt_kind`=bits 3:2, `cond`=bits 6:4, `opcode`=bits 13:8, `op_size`=bits 15:14. Bit 7 is reserved.
- R2: Opcode slot classes are fixed per opcode.
  - No operand: 0x00, 0x0C, 0x0D, 0x10, 0x1C, 0x1D, 0x20, 0x2A, 0x3A.
  - Source only: 0x08, 0x09, 0x0A, 0x11, 0x18, 0x19, 0x1A, 0x28, 0x29, 0x2C, 0x2D, 0x31, 0x33, 0x3D.
  - Source and target: 0x01-0x07, 0x0B, 0x13-0x17, 0x1B, 0x21-0x27, 0x32, 0x34, 0x35, 0x39.
  - Every other opcode is unlisted.
  - An unused slot reports 0 operand bytes.
- R3: A used slot's byte count depends on its kind.
  - Kind 0 (register) and kind 1 (register pointer) take 1 byte.
  - Kind 2 (immediate) takes 1, 2 or 4 bytes for size codes 0, 1 or 2.
  - Kind 3 (immediate pointer) always takes 4 bytes.
- R4: `insn_len` equals 2 + `src_bytes` + `tgt_bytes`.
- R5: `exec_en` is evaluated from the flags sampled with the word.
  - cond 0: always true.
  - cond 1: Z.
  - cond 2: !Z.
  - cond 3: C.
  - cond 4: !C.
  - cond 5: !Z and !C.
  - cond 6: Z or C.
- R6: Any of the following makes the word illegal: reserved bit 7 set, size code 3, cond 7, or an unlisted opcode. An illegal word sets `bad_insn`, clears `exec_en`, reports 0 operand bytes and a length of 2, and starts no operand phase.
- R7: `dec_valid` rises one cycle after a word is accepted. It stays high for only that cycle unless another word is accepted.
- R8: After a legal word with operands, `busy` stays high until exactly `src_bytes`+`tgt_bytes` operand bytes have been taken. While `busy` is high, `cw_valid` is ignored and the decoded outputs hold.
- R9: When a byte of a register or register-pointer operand is above 34, `bad_reg` pulses in the next cycle. Immediate bytes never raise it.
- R10: After reset, every output is 0 and the machine is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cw_valid | input | 1 | Control word offered |
| cw | input | 16 | Control word, little-endian assembled |
| flag_z | input | 1 | Current zero flag |
| flag_c | input | 1 | Current carry flag |
| opb_valid | input | 1 | Operand byte offered |
| opb | input | 8 | Operand byte |
| dec_valid | output | 1 | New decode result this cycle |
| opcode | output | 6 | Opcode field |
| op_size | output | 2 | Size code |
| cond | output | 3 | Condition code |
| src_kind | output | 2 | Source operand kind |
| tgt_kind | output | 2 | Target operand kind |
| src_bytes | output | 3 | Source operand byte count |
| tgt_bytes | output | 3 | Target operand byte count |
| insn_len | output | 4 | Total instruction length in bytes |
| exec_en | output | 1 | Condition satisfied, execute |
| bad_insn | output | 1 | Illegal encoding |
| bad_reg | output | 1 | Register number out of range |
| busy | output | 1 | Operand phase in progress |

## Verification
The assertions take for granted that every input is a known value and that operand bytes are offered only while `busy` is high. They do not model stray operand bytes in `ST_IDLE`. The stimulus keeps to this: it drives `opb_valid` only inside the operand loop that follows each decode, and it raises `cw_valid` during an operand phase only once, on purpose, to show that the word is ignored. The sweeps cover every opcode, size and operand-kind combination, all condition/flag pairs and the reserved bit. Each operand byte is chosen so that register numbers fall on both sides of 34.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

    typedef enum logic [1:0] {
        OPK_REG  = 2'd0,
        OPK_RPTR = 2'd1,
        OPK_IMM  = 2'd2,
        OPK_IPTR = 2'd3
    } opk_t;

    typedef enum logic [1:0] {
        ARGS_NONE,
        ARGS_SRC,
        ARGS_BOTH,
        ARGS_ILLEGAL
    } argcls_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SRC,
        ST_TGT
    } dec_state_t;

    typedef struct packed {
        logic [1:0] size;
        logic [5:0] opcode;
        logic       rsvd;
        logic [2:0] cond;
        logic [1:0] tgt_kind;
        logic [1:0] src_kind;
    } cw_fields_t;

    function automatic argcls_t opcode_class(input logic [5:0] op);
        argcls_t r;
        unique case (op)
            6'h00, 6'h0C, 6'h0D, 6'h10, 6'h1C, 6'h1D,
            6'h20, 6'h2A, 6'h3A:
                r = ARGS_NONE;
            6'h08, 6'h09, 6'h0A, 6'h11, 6'h18, 6'h19, 6'h1A,
            6'h28, 6'h29, 6'h2C, 6'h2D, 6'h31, 6'h33, 6'h3D:
                r = ARGS_SRC;
            6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
            6'h0B, 6'h13, 6'h14, 6'h15, 6'h16, 6'h17, 6'h1B,
            6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
            6'h32, 6'h34, 6'h35, 6'h39:
                r = ARGS_BOTH;
            default:
                r = ARGS_ILLEGAL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cwd_field_decode.sv
module cwd_field_decode
    import cwd_pkg::*;
(
    input  logic [15:0] cw,
    output cw_fields_t  fields,
    output argcls_t     cls,
    output logic        illegal
);
    always_comb begin
        fields  = cw_fields_t'(cw);
        cls     = opcode_class(fields.opcode);
        illegal = fields.rsvd
                | (fields.size == 2'd3)
                | (fields.cond == 3'd7)
                | (cls == ARGS_ILLEGAL);
    end
endmodule

// File: rtl/cwd_operand_size.sv
module cwd_operand_size
    import cwd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic [1:0]       kind,
    input  logic [1:0]       size,
    input  logic             used,
    output logic [CNT_W-1:0] nbytes
);
    always_comb begin
        nbytes = '0;
        if (used) begin
            unique case (opk_t'(kind))
                OPK_REG, OPK_RPTR: nbytes = CNT_W'(1);
                OPK_IMM:           nbytes = CNT_W'(1) << size[1:0];
                OPK_IPTR:          nbytes = CNT_W'(4);
                default:           nbytes = '0;
            endcase
        end
    end
endmodule

// File: rtl/cwd_cond_eval.sv
module cwd_cond_eval (
    input  logic [2:0] cond,
    input  logic       z,
    input  logic       c,
    output logic       take
);
    always_comb begin
        unique case (cond)
            3'd0:    take = 1'b1;
            3'd1:    take = z;
            3'd2:    take = !z;
            3'd3:    take = c;
            3'd4:    take = !c;
            3'd5:    take = !z && !c;
            3'd6:    take = z || c;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/cwd_decoder.sv
module cwd_decoder
    import cwd_pkg::*;
#(
    parameter int REG_LAST = 34,
    parameter int CNT_W    = 3,
    parameter int LEN_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_valid,
    input  logic [15:0]      cw,
    input  logic             flag_z,
    input  logic             flag_c,
    input  logic             opb_valid,
    input  logic [7:0]       opb,
    output logic             dec_valid,
    output logic [5:0]       opcode,
    output logic [1:0]       op_size,
    output logic [2:0]       cond,
    output logic [1:0]       src_kind,
    output logic [1:0]       tgt_kind,
    output logic [CNT_W-1:0] src_bytes,
    output logic [CNT_W-1:0] tgt_bytes,
    output logic [LEN_W-1:0] insn_len,
    output logic             exec_en,
    output logic             bad_insn,
    output logic             bad_reg,
    output logic             busy
);
    localparam int NSLOT   = 2;
    localparam int HDR_LEN = 2;

    cw_fields_t       fld;
    argcls_t          cls;
    logic             illegal;
    logic             cond_ok;
    logic [1:0]       slot_kind [NSLOT];
    logic             slot_used [NSLOT];
    logic [CNT_W-1:0] slot_bytes[NSLOT];

    cwd_field_decode u_fields (
        .cw      (cw),
        .fields  (fld),
        .cls     (cls),
        .illegal (illegal)
    );

    cwd_cond_eval u_cond (
        .cond (fld.cond),
        .z    (flag_z),
        .c    (flag_c),
        .take (cond_ok)
    );

    assign slot_kind[0] = fld.src_kind;
    assign slot_kind[1] = fld.tgt_kind;
    assign slot_used[0] = !illegal && (cls == ARGS_SRC || cls == ARGS_BOTH);
    assign slot_used[1] = !illegal && (cls == ARGS_BOTH);

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        cwd_operand_size #(.CNT_W(CNT_W)) u_size (
            .kind   (slot_kind[g]),
            .size   (fld.size),
            .used   (slot_used[g]),
            .nbytes (slot_bytes[g])
        );
    end

    dec_state_t       state, state_n;
    logic [CNT_W-1:0] rem, rem_n;
    logic             accept;
    logic [LEN_W-1:0] len_calc;

    assign accept   = cw_valid && (state == ST_IDLE);
    assign busy     = (state != ST_IDLE);
    assign len_calc = LEN_W'(HDR_LEN) + LEN_W'(slot_bytes[0]) + LEN_W'(slot_bytes[1]);

    function automatic logic is_reg_kind(input logic [1:0] k);
        return (opk_t'(k) == OPK_REG) || (opk_t'(k) == OPK_RPTR);
    endfunction

    // next-state logic
    always_comb begin
        state_n = state;
        rem_n   = rem;
        unique case (state)
            ST_IDLE: begin
                if (accept && slot_bytes[0] != '0) begin
                    state_n = ST_SRC;
                    rem_n   = slot_bytes[0];
                end
            end
            ST_SRC: begin
                if (opb_valid) begin
                    if (rem == CNT_W'(1)) begin
                        if (tgt_bytes != '0) begin
                            state_n = ST_TGT;
                            rem_n   = tgt_bytes;
                        end else begin
                            state_n = ST_IDLE;
                            rem_n   = '0;
                        end
                    end else begin
                        rem_n = rem - CNT_W'(1);
                    end
                end
            end
            ST_TGT: begin
                if (opb_valid) begin
                    if (rem == CNT_W'(1)) begin
                        state_n = ST_IDLE;
                        rem_n   = '0;
                    end else begin
                        rem_n = rem - CNT_W'(1);
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                rem_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rem   <= '0;
        end else begin
            state <= state_n;
            rem   <= rem_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            opcode    <= '0;
            op_size   <= '0;
            cond      <= '0;
            src_kind  <= '0;
            tgt_kind  <= '0;
            src_bytes <= '0;
            tgt_bytes <= '0;
            insn_len  <= '0;
            exec_en   <= 1'b0;
            bad_insn  <= 1'b0;
            bad_reg   <= 1'b0;
        end else begin
            dec_valid <= accept;
            if (accept) begin
                opcode    <= fld.opcode;
                op_size   <= fld.size;
                cond      <= fld.cond;
                src_kind  <= fld.src_kind;
                tgt_kind  <= fld.tgt_kind;
                src_bytes <= slot_bytes[0];
                tgt_bytes <= slot_bytes[1];
                insn_len  <= len_calc;
                exec_en   <= cond_ok && !illegal;
                bad_insn  <= illegal;
            end
            bad_reg <= opb_valid && (opb > 8'(REG_LAST)) &&
                       (((state == ST_SRC) && is_reg_kind(src_kind)) ||
                        ((state == ST_TGT) && is_reg_kind(tgt_kind)));
        end
    end
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
    parameter int CNT_W = 3,
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cw_valid,
    input logic             opb_valid,
    input logic             dec_valid,
    input logic [1:0]       src_kind,
    input logic [CNT_W-1:0] src_bytes,
    input logic [CNT_W-1:0] tgt_bytes,
    input logic [LEN_W-1:0] insn_len,
    input logic             exec_en,
    input logic             bad_insn,
    input logic             bad_reg,
    input logic             busy
);
    a_r7_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(cw_valid) && !$past(busy));

    a_r4_length: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> insn_len == LEN_W'(2) + LEN_W'(src_bytes) + LEN_W'(tgt_bytes));

    a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && bad_insn) |-> !exec_en && src_bytes == '0 && tgt_bytes == '0 && !busy);

    a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cw_valid) |=> !dec_valid);

    a_r9_badreg_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bad_reg |-> $past(opb_valid) && $past(busy));

    a_r3_iptr_four: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !bad_insn && src_bytes != '0 && src_kind == 2'd3) |-> src_bytes == CNT_W'(4));
endmodule

bind cwd_decoder cwd_checker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_valid  (cw_valid),
    .opb_valid (opb_valid),
    .dec_valid (dec_valid),
    .src_kind  (src_kind),
    .src_bytes (src_bytes),
    .tgt_bytes (tgt_bytes),
    .insn_len  (insn_len),
    .exec_en   (exec_en),
    .bad_insn  (bad_insn),
    .bad_reg   (bad_reg),
    .busy      (busy)
);

// File: tb/cwd_decoder_tb_top.sv
module cwd_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_valid = 1'b0;
    logic [15:0] cw = '0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic        opb_valid = 1'b0;
    logic [7:0]  opb = '0;
    logic        dec_valid, exec_en, bad_insn, bad_reg, busy;
    logic [5:0]  opcode;
    logic [1:0]  op_size, src_kind, tgt_kind;
    logic [2:0]  cond, src_bytes, tgt_bytes;
    logic [3:0]  insn_len;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cwd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw(cw),
        .flag_z(flag_z), .flag_c(flag_c), .opb_valid(opb_valid), .opb(opb),
        .dec_valid(dec_valid), .opcode(opcode), .op_size(op_size), .cond(cond),
        .src_kind(src_kind), .tgt_kind(tgt_kind), .src_bytes(src_bytes),
        .tgt_bytes(tgt_bytes), .insn_len(insn_len), .exec_en(exec_en),
        .bad_insn(bad_insn), .bad_reg(bad_reg), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // 0 none, 1 source, 2 both, 3 unlisted (R2 lists)
    function automatic int model_class(input int op);
        case (op)
            'h00, 'h0C, 'h0D, 'h10, 'h1C, 'h1D, 'h20, 'h2A, 'h3A: return 0;
            'h08, 'h09, 'h0A, 'h11, 'h18, 'h19, 'h1A, 'h28, 'h29,
            'h2C, 'h2D, 'h31, 'h33, 'h3D: return 1;
            'h0B, 'h1B, 'h32, 'h34, 'h35, 'h39: return 2;
            default: begin
                if ((op >= 'h01 && op <= 'h07) || (op >= 'h13 && op <= 'h17) ||
                    (op >= 'h21 && op <= 'h27)) return 2;
                return 3;
            end
        endcase
    endfunction

    function automatic int model_bytes(input int kind, input int sz);
        if (kind <= 1) return 1;
        if (kind == 2) return 1 << sz;
        return 4;
    endfunction

    function automatic bit model_cond(input int cd, input bit z, input bit c);
        case (cd)
            0: return 1'b1;
            1: return z;
            2: return !z;
            3: return c;
            4: return !c;
            5: return !z && !c;
            6: return z || c;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_word(input logic [15:0] w, input bit z, input bit c);
        int op, sz, cd, sk, tk, cl, sb, tb, ln;
        bit ill, ex;
        op = int'(w[13:8]); sz = int'(w[15:14]); cd = int'(w[6:4]);
        sk = int'(w[1:0]);  tk = int'(w[3:2]);
        cl = model_class(op);
        ill = w[7] || sz == 3 || cd == 7 || cl == 3;
        sb = (!ill && (cl == 1 || cl == 2)) ? model_bytes(sk, sz) : 0;
        tb = (!ill && cl == 2) ? model_bytes(tk, sz) : 0;
        ln = 2 + sb + tb;
        ex = !ill && model_cond(cd, z, c);

        @(negedge clk);
        cw = w; flag_z = z; flag_c = c; cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0;
        chk(dec_valid == 1'b1, "R7", "dec_valid", int'(dec_valid), 1);
        chk(opcode == op[5:0] && op_size == sz[1:0] && cond == cd[2:0] &&
            src_kind == sk[1:0] && tgt_kind == tk[1:0], "R1", "fields", int'(w), int'(w));
        chk(int'(src_bytes) == sb, "R3", "src_bytes", int'(src_bytes), sb);
        chk(int'(tgt_bytes) == tb, "R2", "tgt_bytes", int'(tgt_bytes), tb);
        chk(int'(insn_len) == ln, "R4", "insn_len", int'(insn_len), ln);
        chk(exec_en == ex, "R5", "exec_en", int'(exec_en), int'(ex));
        chk(bad_insn == ill, "R6", "bad_insn", int'(bad_insn), int'(ill));
        for (int i = 0; i < sb + tb; i++) begin
            int kind;
            logic [7:0] b;
            bit expbad;
            kind = (i < sb) ? sk : tk;
            b = 8'((i * 29 + int'(w)) & 8'h3F);
            expbad = (kind <= 1) && (b > 8'd34);
            chk(busy == 1'b1, "R8", "busy during operands", int'(busy), 1);
            opb = b; opb_valid = 1'b1;
            @(negedge clk);
            opb_valid = 1'b0;
            chk(bad_reg == expbad, "R9", "bad_reg", int'(bad_reg), int'(expbad));
        end
        chk(busy == 1'b0, "R8", "busy after operands", int'(busy), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dec_valid == 0 && busy == 0 && bad_insn == 0 && bad_reg == 0 &&
            exec_en == 0 && insn_len == 0 && opcode == 0, "R10", "reset outputs",
            int'(insn_len), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && dec_valid == 0, "R10", "idle after reset", int'(busy), 0);

        // R1 R2 R3 R4 R6: every opcode, size and kind pair, cond always
        for (int op = 0; op < 64; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int sk = 0; sk < 4; sk++)
                    for (int tk = 0; tk < 4; tk++)
                        run_word({sz[1:0], op[5:0], 1'b0, 3'd0, tk[1:0], sk[1:0]}, 1'b0, 1'b0);

        // R5 R6: every condition against every flag pair
        for (int cd = 0; cd < 8; cd++)
            for (int f = 0; f < 4; f++)
                run_word({2'd2, 6'h00, 1'b0, cd[2:0], 4'h0}, f[1], f[0]);

        // R6: reserved bit set
        run_word({2'd0, 6'h01, 1'b1, 3'd0, 4'h0}, 1'b0, 1'b0);
        run_word({2'd2, 6'h17, 1'b1, 3'd1, 4'h6}, 1'b1, 1'b0);

        // R8: a word offered while busy is ignored
        run_word({2'd2, 6'h01, 1'b0, 3'd0, 2'b00, 2'b10}, 1'b0, 1'b0);
        @(negedge clk);
        cw = {2'd2, 6'h01, 1'b0, 3'd0, 2'b00, 2'b10}; cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0;
        cw = {2'd0, 6'h10, 1'b0, 3'd0, 4'h0}; cw_valid = 1'b1;
        @(negedge clk);
        cw_valid = 1'b0;
        chk(dec_valid == 1'b0, "R8", "busy ignores word", int'(dec_valid), 0);
        chk(opcode == 6'h01 && insn_len == 4'd7, "R8", "outputs held", int'(opcode), 1);
        for (int i = 0; i < 5; i++) begin
            opb = 8'hFF; opb_valid = 1'b1;
            @(negedge clk);
            opb_valid = 1'b0;
            if (i < 4) chk(bad_reg == 1'b0, "R9", "immediate byte", int'(bad_reg), 0);
            else       chk(bad_reg == 1'b1, "R9", "register 255", int'(bad_reg), 1);
        end
        chk(busy == 1'b0, "R8", "busy after 5 bytes", int'(busy), 0);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R7", "dec_valid single pulse", int'(dec_valid), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule